// File: doc/BRIEF.md
# MAC Pause and Backpressure Controller

This block gates the transmit path of an Ethernet MAC for flow control. A received PAUSE request, which the frame parser delivers as a one-cycle strobe with a 16-bit pause value, loads a quanta timer. The timer counts down one quantum for each group of byte-time ticks. A quantum is 64 byte-times in normal operation, or a single byte-time when the quantum-shortcut test control is set. While the timer is nonzero, the block holds an inhibit output that stops the transmit scheduler from starting a frame.

Two further controls are provided. The forced-pause control inhibits transmission as if a nonzero pause were in progress. The backpressure control makes the block request preamble on the line so that carrier sense rises at the link partner. A frame that the system has queued is still granted during backpressure, and preamble is not requested while that frame is granted.

Top module: `mac_flow_gate`

## Requirements
- R1: After reset, with no input activity, `tx_inhibit`, `jam_preamble` and `carrier_out` are 0, and `tx_go` follows `tx_req`.
- R2: With `ctl_quanta_short`=0, a pause value N (N>0) holds `tx_inhibit` at 1 for exactly 64*N byte-time ticks after the load. The output falls after the clock edge that takes the last tick.
- R3: With `ctl_quanta_short`=1, a pause value N (N>0) holds `tx_inhibit` at 1 for exactly N byte-time ticks.
- R4: A pause strobe that arrives during a pause replaces the remaining count with the new value. It does not add to the count, and it restarts the partial quantum, so the next quantum again takes a full 64 ticks.
- R5: A pause strobe with value 0 clears any pause in progress, and `tx_inhibit` is 0 from the next clock edge.
- R6: While `ctl_force_pause`=1, `tx_inhibit` is 1 whatever the timer holds. When the control is cleared with no count left, `tx_inhibit` returns to 0.
- R7: `tx_go` is `tx_req` gated by the inverse of `tx_inhibit`.
- R8: While `ctl_backpressure`=1 and no frame is granted (`tx_go`=0), `jam_preamble` is 1. `carrier_out` is 1 whenever `jam_preamble` or `tx_go` is 1.
- R9: Backpressure does not inhibit: with `ctl_backpressure`=1 and no pause, a queued frame (`tx_req`=1) gets `tx_go`=1 and `jam_preamble`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_tick | input | 1 | One-cycle pulse per byte-time |
| pause_load | input | 1 | One-cycle strobe: a PAUSE request was received |
| pause_value | input | 16 | Pause time in quanta, valid with `pause_load` |
| ctl_quanta_short | input | 1 | Test control: one quantum is one byte-time |
| ctl_force_pause | input | 1 | Test control: inhibit as if paused |
| ctl_backpressure | input | 1 | Request preamble on the line to raise carrier sense |
| tx_req | input | 1 | The scheduler has a frame queued |
| tx_inhibit | output | 1 | Transmission start is blocked |
| tx_go | output | 1 | Queued frame may be sent |
| jam_preamble | output | 1 | Drive preamble for backpressure |
| carrier_out | output | 1 | The line is being driven (preamble or frame) |

## Verification
On every cycle, assertions check the following. The count takes the strobed value on a load. It never moves except down by one on a tick. It stays at zero once zero. With the shortcut set, it drops on every tick. Inhibit and grant never coexist, and preamble and a granted frame are never requested together. Only the bench's scenarios can show the exact tick totals: 64 per quantum, one per quantum under the shortcut, the restart of a partial quantum on reload, and the clearing by a zero value. The same holds for the end-to-end behaviour of the forced pause and of backpressure with a queued frame.

// File: rtl/mac_flow_pkg.sv
package mac_flow_pkg;
   localparam int unsigned PAUSE_W_DEF       = 16;
   localparam int unsigned QUANTUM_BYTES_DEF = 64;

   typedef struct packed {
      logic quanta_short;
      logic force_pause;
      logic backpressure;
   } flow_ctl_t;
endpackage

// File: rtl/mfg_byte_divider.sv
module mfg_byte_divider #(
   parameter int unsigned QUANTUM_BYTES = 64,
   parameter bit          HAS_SHORTCUT  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic restart,
   input  logic run,
   input  logic shortcut,
   output logic quantum_end
);
   localparam int unsigned CNT_W   = $clog2(QUANTUM_BYTES);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(QUANTUM_BYTES - 1);

   initial begin
      if (QUANTUM_BYTES < 2 || (QUANTUM_BYTES & (QUANTUM_BYTES - 1)) != 0)
         $error("QUANTUM_BYTES must be a power of two of at least 2");
   end

   logic [CNT_W-1:0] byte_cnt;
   logic             short_eff;
   logic             wrap;

   generate
      if (HAS_SHORTCUT) begin : g_short
         assign short_eff = shortcut;
      end else begin : g_no_short
         logic unused_short;
         assign unused_short = shortcut;
         assign short_eff    = 1'b0;
      end
   endgenerate

   assign wrap        = short_eff || (byte_cnt == CNT_MAX);
   assign quantum_end = tick && run && !restart && wrap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         byte_cnt <= '0;
      end else if (restart || !run) begin
         byte_cnt <= '0;
      end else if (tick) begin
         byte_cnt <= wrap ? '0 : byte_cnt + 1'b1;
      end
   end

   AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !restart) |=> (byte_cnt == '0)); // R4
endmodule

// File: rtl/mfg_quanta_timer.sv
module mfg_quanta_timer #(
   parameter int unsigned PAUSE_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [PAUSE_W-1:0] load_value,
   input  logic               quantum_end,
   input  logic               tick,
   output logic [PAUSE_W-1:0] remaining,
   output logic               active
);
   initial begin
      if (PAUSE_W < 1 || PAUSE_W > 32)
         $error("PAUSE_W must lie in 1..32");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remaining <= '0;
      end else if (load) begin
         remaining <= load_value;
      end else if (quantum_end && remaining != '0) begin
         remaining <= remaining - 1'b1;
      end
   end

   assign active = (remaining != '0);

   AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (remaining == $past(load_value))); // R4
   AST_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && remaining != '0) |=>
         (remaining == $past(remaining) || remaining == $past(remaining) - 1'b1)); // R2
   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !tick) |=> $stable(remaining)); // R2
   AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && remaining == '0) |=> (remaining == '0)); // R5
endmodule

// File: rtl/mfg_tx_arbiter.sv
module mfg_tx_arbiter (
   input  logic clk,
   input  logic rst_n,
   input  logic paused,
   input  logic force_pause,
   input  logic backpressure,
   input  logic tx_req,
   output logic tx_inhibit,
   output logic tx_go,
   output logic jam_preamble,
   output logic carrier_out
);
   assign tx_inhibit   = paused || force_pause;
   assign tx_go        = tx_req && !tx_inhibit;
   assign jam_preamble = backpressure && !tx_go;
   assign carrier_out  = jam_preamble || tx_go;

   AST_GO_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      tx_inhibit |-> !tx_go); // R7
   AST_JAM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(jam_preamble && tx_go)); // R8
   AST_FORCE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      force_pause |-> tx_inhibit); // R6
endmodule

// File: rtl/mac_flow_gate.sv
module mac_flow_gate
   import mac_flow_pkg::*;
#(
   parameter int unsigned PAUSE_W       = PAUSE_W_DEF,
   parameter int unsigned QUANTUM_BYTES = QUANTUM_BYTES_DEF,
   parameter bit          HAS_SHORTCUT  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               byte_tick,
   input  logic               pause_load,
   input  logic [PAUSE_W-1:0] pause_value,
   input  logic               ctl_quanta_short,
   input  logic               ctl_force_pause,
   input  logic               ctl_backpressure,
   input  logic               tx_req,
   output logic               tx_inhibit,
   output logic               tx_go,
   output logic               jam_preamble,
   output logic               carrier_out
);
   flow_ctl_t        ctl;
   logic             q_end;
   logic             paused;
   logic [PAUSE_W-1:0] remaining;

   assign ctl = '{quanta_short: ctl_quanta_short,
                  force_pause:  ctl_force_pause,
                  backpressure: ctl_backpressure};

   mfg_byte_divider #(
      .QUANTUM_BYTES (QUANTUM_BYTES),
      .HAS_SHORTCUT  (HAS_SHORTCUT)
   ) u_div (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (byte_tick),
      .restart     (pause_load),
      .run         (paused),
      .shortcut    (ctl.quanta_short),
      .quantum_end (q_end)
   );

   mfg_quanta_timer #(
      .PAUSE_W (PAUSE_W)
   ) u_tmr (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (pause_load),
      .load_value  (pause_value),
      .quantum_end (q_end),
      .tick        (byte_tick),
      .remaining   (remaining),
      .active      (paused)
   );

   mfg_tx_arbiter u_arb (
      .clk          (clk),
      .rst_n        (rst_n),
      .paused       (paused),
      .force_pause  (ctl.force_pause),
      .backpressure (ctl.backpressure),
      .tx_req       (tx_req),
      .tx_inhibit   (tx_inhibit),
      .tx_go        (tx_go),
      .jam_preamble (jam_preamble),
      .carrier_out  (carrier_out)
   );

   AST_SHORT_EVERY_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_SHORTCUT && ctl_quanta_short && byte_tick && !pause_load && remaining != '0)
         |=> (remaining == $past(remaining) - 1'b1)); // R3
   AST_ZERO_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (pause_load && pause_value == '0 && !ctl_force_pause) |=>
         (!tx_inhibit || ctl_force_pause)); // R5
endmodule

// File: tb/mac_flow_gate_tb_top.sv
module mac_flow_gate_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        byte_tick = 1'b0;
   logic        pause_load = 1'b0;
   logic [15:0] pause_value = '0;
   logic        ctl_quanta_short = 1'b0;
   logic        ctl_force_pause = 1'b0;
   logic        ctl_backpressure = 1'b0;
   logic        tx_req = 1'b0;
   logic        tx_inhibit, tx_go, jam_preamble, carrier_out;

   int errors = 0;
   int checks = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   mac_flow_gate dut_i (
      .clk(clk), .rst_n(rst_n), .byte_tick(byte_tick),
      .pause_load(pause_load), .pause_value(pause_value),
      .ctl_quanta_short(ctl_quanta_short), .ctl_force_pause(ctl_force_pause),
      .ctl_backpressure(ctl_backpressure), .tx_req(tx_req),
      .tx_inhibit(tx_inhibit), .tx_go(tx_go),
      .jam_preamble(jam_preamble), .carrier_out(carrier_out)
   );

   // vector: [32:17] pause value, [16] shortcut, [15:0] expected ticks
   localparam logic [32:0] VEC [6] = '{
      {16'd1,   1'b1, 16'd1},
      {16'd5,   1'b1, 16'd5},
      {16'd300, 1'b1, 16'd300},
      {16'd1,   1'b0, 16'd64},
      {16'd3,   1'b0, 16'd192},
      {16'd0,   1'b0, 16'd0}
   };

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual cycles=%0d expected end before 150000", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk) byte_tick = 1'b1;
      @(negedge clk) byte_tick = 1'b0;
   endtask

   task automatic load(input logic [15:0] v);
      @(negedge clk) begin pause_load = 1'b1; pause_value = v; end
      @(negedge clk) pause_load = 1'b0;
   endtask

   task automatic run_out(output int n);
      n = 0;
      while (tx_inhibit && n < 1000) begin
         tick();
         n++;
      end
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 inhibit", tx_inhibit, 0);
      check("R1 jam", jam_preamble, 0);
      check("R1 carrier", carrier_out, 0);
      tx_req = 1'b1; #1;
      check("R1 go follows req", tx_go, 1);
      tx_req = 1'b0;

      foreach (VEC[i]) begin
         ctl_quanta_short = VEC[i][16];
         load(VEC[i][32:17]);
         check(VEC[i][16] ? "R3 inhibit after load" : "R2 inhibit after load",
               tx_inhibit, VEC[i][32:17] != 0);
         run_out(n);
         check(VEC[i][16] ? "R3 tick total" : "R2 tick total", n, VEC[i][15:0]);
      end

      // R4: reload replaces count (shortcut)
      ctl_quanta_short = 1'b1;
      load(16'd10);
      repeat (4) tick();
      load(16'd3);
      run_out(n);
      check("R4 reload replaces", n, 3);

      // R4: reload restarts partial quantum (normal)
      ctl_quanta_short = 1'b0;
      load(16'd1);
      repeat (30) tick();
      load(16'd1);
      run_out(n);
      check("R4 partial quantum restarts", n, 64);

      // R5: zero value clears
      ctl_quanta_short = 1'b1;
      load(16'd10);
      repeat (2) tick();
      check("R5 still paused", tx_inhibit, 1);
      load(16'd0);
      check("R5 zero clears", tx_inhibit, 0);

      // R6 / R7: forced pause
      ctl_quanta_short = 1'b0;
      @(negedge clk) begin ctl_force_pause = 1'b1; tx_req = 1'b1; end
      #1;
      check("R6 forced inhibit", tx_inhibit, 1);
      check("R7 go blocked", tx_go, 0);
      repeat (3) tick();
      check("R6 held over ticks", tx_inhibit, 1);
      @(negedge clk) ctl_force_pause = 1'b0;
      #1;
      check("R6 release", tx_inhibit, 0);
      check("R7 go released", tx_go, 1);

      // R8 / R9: backpressure
      @(negedge clk) begin ctl_backpressure = 1'b1; tx_req = 1'b0; end
      #1;
      check("R8 jam idle", jam_preamble, 1);
      check("R8 carrier", carrier_out, 1);
      check("R9 no inhibit", tx_inhibit, 0);
      tx_req = 1'b1; #1;
      check("R9 queued frame sent", tx_go, 1);
      check("R9 jam yields", jam_preamble, 0);
      check("R8 carrier with frame", carrier_out, 1);
      // R8: paused with backpressure still jams
      ctl_quanta_short = 1'b1;
      load(16'd2);
      check("R8 jam while paused", jam_preamble, 1);
      check("R7 blocked while paused", tx_go, 0);
      run_out(n);
      check("R3 run out with bp", n, 2);
      @(negedge clk) begin ctl_backpressure = 1'b0; tx_req = 1'b0; end
      #1;
      check("R8 jam off", jam_preamble, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule